// File: doc/BRIEF.md
# Two-Phase 8-bit Register Processor Core

This block is a minimal 8-bit processor that runs 11-bit instruction words which have already been error-corrected upstream. It holds four 8-bit general registers, a 16-byte data store, an 8-bit program counter that reaches 256 instruction slots, and four sticky condition flags. Each instruction takes two clock cycles. The core alternates between a fetch phase and an execute phase.

In the fetch phase (`PH_FETCH`) the core latches the word on `imem_data` for the address on `imem_addr`. In the same cycle it commits any ALU result left pending by the previous instruction. In the execute phase (`PH_EXEC`) it decodes the latched word and does one of these:

- loads an immediate;
- runs the ALU and updates the flags;
- reads or writes the data store;
- takes or skips a jump.

It then advances the program counter. The phase transitions are fixed:

- `PH_FETCH -> PH_EXEC` on every clock;
- `PH_EXEC -> PH_FETCH` on every clock;
- synchronous reset forces `PH_FETCH`.

Two data-store addresses connect to the outside world. Byte 14 is always visible on `io_out`. A load from byte 13 returns `io_in`.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, clears the program counter, all four registers, all 16 data bytes and the flags, and leaves the core in `PH_FETCH`. The first fetch after reset is from address 0 and `io_out` reads 0.
- R2: Every instruction takes exactly two cycles, one fetch and one execute. `imem_addr` changes only on the execute edge. Any instruction that is not a taken jump advances it by one, wrapping modulo 256.
- R3: A word with bit 10 set is a load-immediate. It writes bits 7:0 into the register selected by bits 9:8.
- R4: Class `001` (bits 10:8) is an ALU operation on R = register bits 3:2 and S = register bits 1:0, selected by bits 7:4: 0 AND, 1 OR, 2 R+S, 3 R-S, 4 R+1, 5 R-1, 8 compare. The result is written to R in the following fetch phase, so the next instruction already sees it.
- R5: Compare (op 8) sets the flags and writes no register. Class `000` (no-op) changes nothing except the program counter. ALU codes outside the list above change nothing.
- R6: Flags are Z (result zero), N (result bit 7), C (carry out for add and increment, borrow for subtract, decrement and compare, 0 for logic ops) and V (signed overflow, 0 for logic ops). Only ALU-class instructions change them. All other instructions leave them at their last value.
- R7: Class `010` accesses the data store, with bits 3:2 as the sub-operation and bits 1:0 as the data register: 00 load from address bits 7:4; 01 load from the address in the low 4 bits of the register in bits 5:4; 10 store to address bits 7:4; 11 store to the address in the low 4 bits of the register in bits 5:4.
- R8: Data byte 14 drives `io_out` continuously. A load from address 13 returns `io_in` instead of the stored byte.
- R9: Class `011` is a jump to the address held in the register in bits 1:0, taken when condition bits 7:4 are true: 0 always, 1 Z, 2 N, 3 C, 4 unsigned greater (!C & !Z), 5 unsigned less (C), 6 unsigned greater-or-equal (!C), 7 unsigned less-or-equal (C | Z), 8 equal (Z), 12 signed greater (!Z & N==V), 13 signed less (N!=V), 14 signed greater-or-equal (N==V), 15 signed less-or-equal (Z | N!=V). Codes 9 to 11 are never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction address (program counter) |
| imem_data | input | 11 | Corrected instruction word at `imem_addr` |
| io_in | input | 8 | Byte returned by loads from data address 13 |
| io_out | output | 8 | Current content of data byte 14 |

## Verification
The assertions assume the following about the inputs:

- `imem_data` is a defined function of `imem_addr` that settles within the fetch cycle.
- `rst` is sampled only at clock edges.

The bench keeps to these assumptions. It models instruction memory as a combinational array indexed by `imem_addr`, rewrites that array and changes `io_in` only while reset is held, and moves `rst` only on falling edges. Because of this, the phase and sticky-flag properties see a clean alternation of fetch and execute from the first edge after reset.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;
    localparam int DW     = 8;
    localparam int IW     = 11;
    localparam int PCW    = 8;
    localparam int NREG   = 4;
    localparam int RSELW  = $clog2(NREG);
    localparam int DDEPTH = 16;
    localparam int DAW    = $clog2(DDEPTH);

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_t;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    localparam logic [3:0] OP_AND = 4'd0;
    localparam logic [3:0] OP_OR  = 4'd1;
    localparam logic [3:0] OP_ADD = 4'd2;
    localparam logic [3:0] OP_SUB = 4'd3;
    localparam logic [3:0] OP_INC = 4'd4;
    localparam logic [3:0] OP_DEC = 4'd5;
    localparam logic [3:0] OP_CMP = 4'd8;

    localparam logic [2:0] CLS_NOP = 3'b000;
    localparam logic [2:0] CLS_ALU = 3'b001;
    localparam logic [2:0] CLS_MEM = 3'b010;
    localparam logic [2:0] CLS_JMP = 3'b011;
endpackage

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
(
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output flags_t        fl,
    output logic          writes,
    output logic          sets
);
    logic [DW-1:0] y;
    logic [DW:0]   wide;
    logic          arith;
    logic          subtract;

    always_comb begin
        arith    = 1'b0;
        subtract = 1'b0;
        writes   = 1'b0;
        sets     = 1'b0;
        y        = b;
        res      = '0;
        wide     = '0;
        unique case (op)
            OP_AND: begin res = a & b; writes = 1'b1; sets = 1'b1; end
            OP_OR:  begin res = a | b; writes = 1'b1; sets = 1'b1; end
            OP_ADD: begin arith = 1'b1; writes = 1'b1; sets = 1'b1; end
            OP_SUB: begin arith = 1'b1; subtract = 1'b1; writes = 1'b1; sets = 1'b1; end
            OP_INC: begin arith = 1'b1; y = DW'(1); writes = 1'b1; sets = 1'b1; end
            OP_DEC: begin arith = 1'b1; subtract = 1'b1; y = DW'(1); writes = 1'b1; sets = 1'b1; end
            OP_CMP: begin arith = 1'b1; subtract = 1'b1; sets = 1'b1; end
            default: ;
        endcase
        if (arith) begin
            wide = subtract ? ({1'b0, a} - {1'b0, y}) : ({1'b0, a} + {1'b0, y});
            res  = wide[DW-1:0];
        end
        fl.z = (res == '0);
        fl.n = res[DW-1];
        fl.c = arith & wide[DW];
        if (!arith)
            fl.v = 1'b0;
        else if (subtract)
            fl.v = (a[DW-1] != y[DW-1]) && (res[DW-1] != a[DW-1]);
        else
            fl.v = (a[DW-1] == y[DW-1]) && (res[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/tiny8_cond.sv
module tiny8_cond
    import tiny8_pkg::*;
(
    input  flags_t     fl,
    input  logic [3:0] code,
    output logic       take
);
    always_comb begin
        unique case (code)
            4'd0:    take = 1'b1;
            4'd1:    take = fl.z;
            4'd2:    take = fl.n;
            4'd3:    take = fl.c;
            4'd4:    take = !fl.c && !fl.z;
            4'd5:    take = fl.c;
            4'd6:    take = !fl.c;
            4'd7:    take = fl.c || fl.z;
            4'd8:    take = fl.z;
            4'd12:   take = !fl.z && (fl.n == fl.v);
            4'd13:   take = (fl.n != fl.v);
            4'd14:   take = (fl.n == fl.v);
            4'd15:   take = fl.z || (fl.n != fl.v);
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/tiny8_dmem.sv
module tiny8_dmem
    import tiny8_pkg::*;
#(
    parameter int DEPTH    = DDEPTH,
    parameter int OUT_ADDR = 14,
    parameter int IN_ADDR  = 13,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] io_in,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] io_out
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata  = (addr == AW'(IN_ADDR)) ? io_in : mem[addr];
    assign io_out = mem[OUT_ADDR];
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    output logic [PCW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_data,
    input  logic [DW-1:0]  io_in,
    output logic [DW-1:0]  io_out
);
    phase_t           phase;
    logic [IW-1:0]    ir;
    logic [PCW-1:0]   pc;
    logic [DW-1:0]    regs [NREG];
    flags_t           flags;
    logic             wb_valid;
    logic [RSELW-1:0] wb_dst;
    logic [DW-1:0]    wb_val;

    // decoded controls
    logic             is_ldi, is_alu, is_mem, is_jmp, in_exec;
    logic [DW-1:0]    alu_res;
    flags_t           alu_fl;
    logic             alu_writes, alu_sets;
    logic             cond_ok, jump_taken;
    logic [DAW-1:0]   mem_addr;
    logic [DW-1:0]    mem_rdata;
    logic             mem_we;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            unique case (phase)
                PH_FETCH: phase <= PH_EXEC;
                PH_EXEC:  phase <= PH_FETCH;
            endcase
        end
    end

    // decode (outputs of the current phase)
    always_comb begin
        in_exec    = (phase == PH_EXEC);
        is_ldi     = ir[IW-1];
        is_alu     = !ir[IW-1] && (ir[IW-2:IW-3] == CLS_ALU[1:0]);
        is_mem     = !ir[IW-1] && (ir[IW-2:IW-3] == CLS_MEM[1:0]);
        is_jmp     = !ir[IW-1] && (ir[IW-2:IW-3] == CLS_JMP[1:0]);
        mem_addr   = ir[2] ? regs[ir[5:4]][DAW-1:0] : ir[7:4];
        mem_we     = in_exec && is_mem && ir[3];
        jump_taken = is_jmp && cond_ok;
    end

    assign imem_addr = pc;

    tiny8_alu u_alu (
        .op     (ir[7:4]),
        .a      (regs[ir[3:2]]),
        .b      (regs[ir[1:0]]),
        .res    (alu_res),
        .fl     (alu_fl),
        .writes (alu_writes),
        .sets   (alu_sets)
    );

    tiny8_cond u_cond (
        .fl   (flags),
        .code (ir[7:4]),
        .take (cond_ok)
    );

    tiny8_dmem u_dmem (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .addr   (mem_addr),
        .wdata  (regs[ir[1:0]]),
        .io_in  (io_in),
        .rdata  (mem_rdata),
        .io_out (io_out)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ir       <= '0;
            pc       <= '0;
            flags    <= '0;
            wb_valid <= 1'b0;
            wb_dst   <= '0;
            wb_val   <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            unique case (phase)
                PH_FETCH: begin
                    ir       <= imem_data;
                    wb_valid <= 1'b0;
                    if (wb_valid) regs[wb_dst] <= wb_val;
                end
                PH_EXEC: begin
                    pc       <= jump_taken ? regs[ir[1:0]] : pc + PCW'(1);
                    wb_valid <= is_alu && alu_writes;
                    wb_dst   <= ir[3:2];
                    wb_val   <= alu_res;
                    if (is_alu && alu_sets) flags <= alu_fl;
                    if (is_ldi) regs[ir[9:8]] <= ir[7:0];
                    if (is_mem && !ir[3]) regs[ir[1:0]] <= mem_rdata;
                end
            endcase
        end
    end
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk
    import tiny8_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input phase_t         phase,
    input logic [IW-1:0]  ir,
    input logic [PCW-1:0] imem_addr,
    input flags_t         flags,
    input logic           wb_valid,
    input logic [DW-1:0]  io_out
);
    // R1: first edge after reset leaves address 0 and a cleared output byte
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == '0) && (io_out == '0) && (phase == PH_FETCH));

    // R2: phases alternate every cycle
    a_r2_phase_alt: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_EXEC));

    // R2: address never moves on a fetch edge
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> $stable(imem_addr));

    // R2: non-jump instructions step the address by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ir[10:8] != CLS_JMP) |=> (imem_addr == $past(imem_addr) + 8'd1));

    // R5: compare leaves nothing to write back
    a_r5_cmp_nowrite: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ir[10:8] == CLS_ALU && ir[7:4] == OP_CMP) |=> !wb_valid);

    // R6: flags are sticky across non-ALU instructions and fetches
    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH || ir[10:8] != CLS_ALU) |=> $stable(flags));

    // R8: output byte only changes on an execute edge
    a_r8_io_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> $stable(io_out));
endmodule

bind tiny8_core tiny8_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .ir        (ir),
    .imem_addr (imem_addr),
    .flags     (flags),
    .wb_valid  (wb_valid),
    .io_out    (io_out)
);

// File: tb/tiny8_core_tb.sv
module tiny8_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [10:0] imem_data;
    logic [7:0]  io_in = 8'h00;
    logic [7:0]  io_out;
    logic [10:0] rom [256];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign imem_data = rom[imem_addr];

    tiny8_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .io_in     (io_in),
        .io_out    (io_out)
    );

    // encoders
    function automatic logic [10:0] e_ldi(input logic [1:0] r, input logic [7:0] v);
        return {1'b1, r, v};
    endfunction
    function automatic logic [10:0] e_alu(input logic [3:0] op, input logic [1:0] r, input logic [1:0] s);
        return {3'b001, op, r, s};
    endfunction
    function automatic logic [10:0] e_mem(input logic [3:0] hi, input logic [1:0] sub, input logic [1:0] r);
        return {3'b010, hi, sub, r};
    endfunction
    function automatic logic [10:0] e_jmp(input logic [1:0] r, input logic [3:0] c);
        return {3'b011, c, 2'b00, r};
    endfunction

    // {op, a, b, expected}
    localparam logic [27:0] VEC [8] = '{
        {4'd0, 8'hF0, 8'h3C, 8'h30},
        {4'd1, 8'h0F, 8'hA0, 8'hAF},
        {4'd2, 8'h12, 8'h34, 8'h46},
        {4'd2, 8'hFF, 8'h02, 8'h01},
        {4'd3, 8'h50, 8'h20, 8'h30},
        {4'd3, 8'h10, 8'h20, 8'hF0},
        {4'd4, 8'hFF, 8'h77, 8'h00},
        {4'd5, 8'h00, 8'h77, 8'hFF}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) rom[i] = 11'h000;
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic go(input int n);
        @(negedge clk);
        rst = 1'b0;
        repeat (2 * n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cond_prog(input logic [7:0] a, input logic [7:0] b, input logic [3:0] c);
        restart();
        rom[0] = e_ldi(2'd0, a);
        rom[1] = e_ldi(2'd1, b);
        rom[2] = e_alu(4'd8, 2'd0, 2'd1);
        rom[3] = e_ldi(2'd2, 8'h20);
        rom[4] = e_jmp(2'd2, c);
        rom[5] = e_ldi(2'd3, 8'hAA);
        rom[6] = e_mem(4'd14, 2'b10, 2'd3);
        rom[32] = e_ldi(2'd3, 8'h55);
        rom[33] = e_mem(4'd14, 2'b10, 2'd3);
        go(7);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) rom[i] = 11'h000;

        // R1: reset state
        restart();
        @(negedge clk);
        check("R1 reset io_out", io_out, 8'h00);
        check("R1 reset imem_addr", imem_addr, 8'h00);

        // R4 / R3: ALU vector table, result consumed by the very next store
        for (int k = 0; k < 8; k++) begin
            restart();
            rom[0] = e_ldi(2'd0, VEC[k][23:16]);
            rom[1] = e_ldi(2'd1, VEC[k][15:8]);
            rom[2] = e_alu(VEC[k][27:24], 2'd0, 2'd1);
            rom[3] = e_mem(4'd14, 2'b10, 2'd0);
            go(4);
            check($sformatf("R4 alu vector %0d", k), io_out, VEC[k][7:0]);
        end

        // R5: compare writes no register
        restart();
        rom[0] = e_ldi(2'd0, 8'h05);
        rom[1] = e_ldi(2'd1, 8'h09);
        rom[2] = e_alu(4'd8, 2'd0, 2'd1);
        rom[3] = e_mem(4'd14, 2'b10, 2'd0);
        go(4);
        check("R5 cmp keeps R0", io_out, 8'h05);

        // R5 / R2: no-op only advances the counter
        restart();
        rom[0] = e_ldi(2'd0, 8'h11);
        rom[1] = e_mem(4'd14, 2'b10, 2'd0);
        rom[2] = 11'h000;
        rom[3] = 11'h0FF;
        go(4);
        check("R5 nop keeps io_out", io_out, 8'h11);
        check("R2 pc after four", imem_addr, 8'h04);

        // R9: conditional jumps
        cond_prog(8'h03, 8'h07, 4'd5);
        check("R9 unsigned less taken", io_out, 8'h55);
        cond_prog(8'h03, 8'h07, 4'd4);
        check("R9 unsigned greater not taken", io_out, 8'hAA);
        cond_prog(8'h80, 8'h01, 4'd13);
        check("R9 signed less taken", io_out, 8'h55);
        cond_prog(8'h80, 8'h01, 4'd5);
        check("R9 unsigned less not taken", io_out, 8'hAA);
        cond_prog(8'h80, 8'h01, 4'd10);
        check("R9 reserved code never taken", io_out, 8'hAA);

        // R6: flags survive a store between compare and jump
        restart();
        rom[0] = e_ldi(2'd0, 8'h00);
        rom[1] = e_ldi(2'd1, 8'h00);
        rom[2] = e_alu(4'd8, 2'd0, 2'd1);
        rom[3] = e_ldi(2'd2, 8'h20);
        rom[4] = e_mem(4'd3, 2'b10, 2'd0);
        rom[5] = e_jmp(2'd2, 4'd1);
        rom[6] = e_ldi(2'd3, 8'hAA);
        rom[7] = e_mem(4'd14, 2'b10, 2'd3);
        rom[32] = e_ldi(2'd3, 8'h55);
        rom[33] = e_mem(4'd14, 2'b10, 2'd3);
        go(8);
        check("R6 sticky zero flag", io_out, 8'h55);

        // R7: indirect store then indirect load, upper address bits ignored
        restart();
        rom[0] = e_ldi(2'd0, 8'h77);
        rom[1] = e_ldi(2'd1, 8'h35);
        rom[2] = e_mem(4'b0001, 2'b11, 2'd0);
        rom[3] = e_ldi(2'd3, 8'hC5);
        rom[4] = e_mem(4'b0011, 2'b01, 2'd2);
        rom[5] = e_mem(4'd14, 2'b10, 2'd2);
        go(6);
        check("R7 indirect store/load", io_out, 8'h77);

        // R1: data store and registers cleared by reset
        restart();
        rom[0] = e_mem(4'd5, 2'b00, 2'd0);
        rom[1] = e_mem(4'd14, 2'b10, 2'd0);
        go(2);
        check("R1 data cleared", io_out, 8'h00);
        restart();
        rom[0] = e_mem(4'd14, 2'b10, 2'd3);
        go(1);
        check("R1 register cleared", io_out, 8'h00);

        // R8: input port on address 13
        restart();
        io_in = 8'h3C;
        rom[0] = e_mem(4'd13, 2'b00, 2'd1);
        rom[1] = e_mem(4'd14, 2'b10, 2'd1);
        go(2);
        check("R8 io_in load", io_out, 8'h3C);

        // R9 / R2: unconditional jump target
        restart();
        rom[0] = e_ldi(2'd1, 8'h40);
        rom[1] = e_jmp(2'd1, 4'd0);
        go(2);
        check("R9 jump target", imem_addr, 8'h40);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule